// File: doc/BRIEF.md
# Clock Fanout Output Enable and Power-Down Controller

This block decides, for each of the 18 output pairs of a differential clock fanout, whether the pair is driven or held in high impedance. An output runs only when three things agree: the device is powered up, a per-output enable bit in the configuration registers is set, and the active-low enable pin that serves that output is driven low. Some pins serve one output each and two pins serve small groups.

A combined power-good / power-down pin controls the whole block. Its rising edge marks power-up. On that edge the block captures the frequency strap and the tri-level bandwidth strap into the configuration register, and starts the PLL. Its falling edge powers the device down: the PLL stops and every output goes to high impedance. Register contents are kept through power-down.

All pins are synchronized before use. Enable changes are applied only while the output clock is in its low phase, so that no runt pulse can appear. The block drives the PLL bandwidth/bypass mode code, the frequency-select field and the reference-input choice. It does not generate clocks.

Top module: `clkfan_oe_ctrl`

## Requirements
- R1: A change applied to output o sets outEn[o] to 1 only if all three of these hold: pllRun is 1, the register enable bit of output o is 1, and the enable pin serving o is 0. If any one fails, outEn[o] is set to 0.
- R2: Pin mapping. oePinN[0] serves outputs 0 to 4 together. oePinN[k] for k = 1 to 10 serves output k+4 alone. oePinN[11] serves outputs 15 to 17 together.
- R3: About three clocks after pwrGoodPin falls, pllRun is 0 and outEn is all zero. Register contents are kept and read back unchanged.
- R4: After pwrGoodPin rises, pllRun becomes 1 and outEn returns to its register- and pin-qualified value.
- R5: On a power-good rise, the bandwidth strap is captured into pllBwMode. bwLoPin=1 with bwHiPin=0 gives low bandwidth, 2'b00. Both pins 0 gives bypass, 2'b10. bwHiPin=1 gives high bandwidth, 2'b11, and this includes the illegal case where both pins are 1.
- R6: outEn changes only on a clock edge at which clkPhaseLow is 1. While clkPhaseLow is 0, outEn holds its value.
- R7: On a power-good rise, freqPin is captured into bit 2 of register 0 (1 = 100 MHz, 0 = 133 MHz). freqSel shows register 0 bits 2:0. A later software write may overwrite bit 2.
- R8: Register map, where a write takes effect on the edge at which regWrEn is sampled:
  - Register 0: bits 7:6 are the bandwidth mode, bit 5 enables output 17, bit 4 enables output 16, bit 3 is spare, bits 2:0 are the frequency select.
  - Register 1: bits 7:0 enable outputs 7 to 0.
  - Register 2: bits 7:0 enable outputs 15 to 8.
  - Reset values: register 0 is 8'hF5, registers 1 and 2 are 8'hFF.
- R9: Register 3 is read-only. Bit 0 is the synchronized refSelPin level (1 = input A, 0 = input B) and bit 1 is the synchronized freqPin level. Writes to register 3 are ignored. refSelA follows refSelPin.
- R10: A pin change made between edges shows on outEn at the third following clock edge (two synchronizer stages, then the apply stage), provided clkPhaseLow is 1.
- R11: During and after reset, pllRun is 0 and outEn is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrGoodPin | input | 1 | Power-good (high) / power-down (low) pin |
| oePinN | input | 12 | Active-low output enable pins |
| bwLoPin | input | 1 | Low-level detect of the tri-level bandwidth strap |
| bwHiPin | input | 1 | High-level detect of the tri-level bandwidth strap |
| freqPin | input | 1 | Frequency strap, 1 = 100 MHz, 0 = 133 MHz |
| refSelPin | input | 1 | Reference input select, 1 = A, 0 = B |
| clkPhaseLow | input | 1 | High while the output clock is in its low phase |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for write and read |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data at regAddr |
| outEn | output | 18 | Per-output run enable, 0 = high impedance |
| pllRun | output | 1 | PLL running / device powered up |
| pllBwMode | output | 2 | PLL bandwidth mode code |
| freqSel | output | 3 | Frequency select field |
| refSelA | output | 1 | Synchronized reference select |

## Verification
On every cycle, the assertions check four things:
- While powered down, an applied update clears every output.
- Outputs hold still outside the low phase.
- A disabled group pin keeps its whole group off.
- Power-good edges move pllRun.

Only the bench scenarios can show the rest: the exact three-edge pin latency, the mapping of each pin and register bit to its outputs, strap capture under each tri-level combination, that registers are kept across a power-down, and that writes to the read-only register are ignored.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

  typedef struct packed {
    logic capture;  // power-good rise seen this cycle
    logic pwrUp;    // device powered up
    logic apply;    // output clock low phase, safe to update enables
  } fanStrobe_t;

  localparam logic [1:0] BW_LOW    = 2'b00;
  localparam logic [1:0] BW_BYPASS = 2'b10;
  localparam logic [1:0] BW_HIGH   = 2'b11;

  function automatic logic [1:0] bwDecode(input logic lo, input logic hi);
    if (hi)      return BW_HIGH;
    else if (lo) return BW_LOW;
    else         return BW_BYPASS;
  endfunction

endpackage

// File: rtl/clkfan_pwr_ctrl.sv
module clkfan_pwr_ctrl
  import clkfan_pkg::*;
#(
  parameter int NUM_PIN     = 12,
  parameter int SYNC_STAGES = 2,
  localparam int SW         = NUM_PIN + 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwrGoodPin,
  input  logic [NUM_PIN-1:0] oePinN,
  input  logic               bwLoPin,
  input  logic               bwHiPin,
  input  logic               freqPin,
  input  logic               refSelPin,
  input  logic               clkPhaseLow,
  output fanStrobe_t         strobe,
  output logic [NUM_PIN-1:0] oeSync,
  output logic               bwLoSync,
  output logic               bwHiSync,
  output logic               freqSync,
  output logic               refSelSync
);

  logic [SW-1:0] syncChain [SYNC_STAGES];
  logic [SW-1:0] rawBundle;
  logic          pgSync, pgDly, pwrUpQ;

  assign rawBundle = {pwrGoodPin, bwLoPin, bwHiPin, freqPin, refSelPin, oePinN};

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= '0;
        else if (s == 0) syncChain[s] <= rawBundle;
        else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign {pgSync, bwLoSync, bwHiSync, freqSync, refSelSync, oeSync} = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgDly  <= 1'b0;
      pwrUpQ <= 1'b0;
    end else begin
      pgDly <= pgSync;
      if (pgSync && !pgDly)      pwrUpQ <= 1'b1;
      else if (!pgSync && pgDly) pwrUpQ <= 1'b0;
    end
  end

  assign strobe.capture = pgSync && !pgDly;
  assign strobe.pwrUp   = pwrUpQ;
  assign strobe.apply   = clkPhaseLow;

  // R4: a synchronized power-good rise starts the device
  p_rise_power_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pgSync && !pgDly) |=> pwrUpQ);

  // R3: a synchronized power-good fall stops the device
  p_fall_power_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!pgSync && pgDly) |=> !pwrUpQ);

endmodule

// File: rtl/clkfan_oe_path.sv
module clkfan_oe_path
  import clkfan_pkg::*;
#(
  parameter int NUM_OUT  = 18,
  parameter int LO_GRP   = 5,
  parameter int HI_FIRST = 15,
  localparam int NUM_PIN = HI_FIRST - LO_GRP + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  fanStrobe_t         strobe,
  input  logic [NUM_PIN-1:0] oeSync,
  input  logic               bwLoSync,
  input  logic               bwHiSync,
  input  logic               freqSync,
  input  logic               refSelSync,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  output logic [NUM_OUT-1:0] outEn,
  output logic [1:0]         pllBwMode,
  output logic [2:0]         freqSel
);

  logic [NUM_OUT-1:0] regEn, pinGate, target, outEnQ;
  logic [1:0]         bwQ;
  logic               spareQ;
  logic [2:0]         freqQ;

  // configuration registers: write first, strap capture takes priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regEn  <= '1;
      bwQ    <= BW_HIGH;
      spareQ <= 1'b0;
      freqQ  <= 3'b101;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          2'd0: begin
            bwQ        <= regWrData[7:6];
            regEn[17]  <= regWrData[5];
            regEn[16]  <= regWrData[4];
            spareQ     <= regWrData[3];
            freqQ      <= regWrData[2:0];
          end
          2'd1: regEn[7:0]  <= regWrData;
          2'd2: regEn[15:8] <= regWrData;
          default: ;
        endcase
      end
      if (strobe.capture) begin
        bwQ      <= bwDecode(bwLoSync, bwHiSync);
        freqQ[2] <= freqSync;
      end
    end
  end

  // map each output to the pin that serves it
  generate
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_pin
      localparam int PIN = (o < LO_GRP) ? 0 :
                           (o >= HI_FIRST) ? NUM_PIN - 1 : o - LO_GRP + 1;
      assign pinGate[o] = ~oeSync[PIN];
    end
  endgenerate

  assign target = regEn & pinGate & {NUM_OUT{strobe.pwrUp}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outEnQ <= '0;
    else if (strobe.apply) outEnQ <= target;
  end

  always_comb begin
    case (regAddr)
      2'd0:    regRdData = {bwQ, regEn[17], regEn[16], spareQ, freqQ};
      2'd1:    regRdData = regEn[7:0];
      2'd2:    regRdData = regEn[15:8];
      default: regRdData = {6'b0, freqSync, refSelSync};
    endcase
  end

  assign outEn     = outEnQ;
  assign pllBwMode = bwQ;
  assign freqSel   = freqQ;

  // R3: powered down, any applied update leaves every output off
  p_hiz_down_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.apply && !strobe.pwrUp) |=> (outEnQ == '0));

  // R6: nothing moves outside the low phase
  p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.apply |=> $stable(outEnQ));

  // R2: the low group pin high keeps outputs 0..4 off
  p_group_lo_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.apply && oeSync[0]) |=> (outEnQ[LO_GRP-1:0] == '0));

  // R5: high detect wins, including the illegal both-asserted case
  p_bw_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && bwHiSync) |=> (bwQ == BW_HIGH));

endmodule

// File: rtl/clkfan_oe_ctrl.sv
module clkfan_oe_ctrl
  import clkfan_pkg::*;
#(
  parameter int NUM_OUT     = 18,
  parameter int LO_GRP      = 5,
  parameter int HI_FIRST    = 15,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_PIN    = HI_FIRST - LO_GRP + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwrGoodPin,
  input  logic [NUM_PIN-1:0] oePinN,
  input  logic               bwLoPin,
  input  logic               bwHiPin,
  input  logic               freqPin,
  input  logic               refSelPin,
  input  logic               clkPhaseLow,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  output logic [NUM_OUT-1:0] outEn,
  output logic               pllRun,
  output logic [1:0]         pllBwMode,
  output logic [2:0]         freqSel,
  output logic               refSelA
);

  fanStrobe_t         strobe;
  logic [NUM_PIN-1:0] oeSync;
  logic               bwLoSync, bwHiSync, freqSync, refSelSync;

  clkfan_pwr_ctrl #(.NUM_PIN(NUM_PIN), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk, .rstN, .pwrGoodPin, .oePinN, .bwLoPin, .bwHiPin, .freqPin,
    .refSelPin, .clkPhaseLow, .strobe, .oeSync, .bwLoSync, .bwHiSync,
    .freqSync, .refSelSync
  );

  clkfan_oe_path #(.NUM_OUT(NUM_OUT), .LO_GRP(LO_GRP), .HI_FIRST(HI_FIRST)) u_path (
    .clk, .rstN, .strobe, .oeSync, .bwLoSync, .bwHiSync, .freqSync,
    .refSelSync, .regWrEn, .regAddr, .regWrData, .regRdData, .outEn,
    .pllBwMode, .freqSel
  );

  assign pllRun  = strobe.pwrUp;
  assign refSelA = refSelSync;

  // R11: nothing runs while powered down after reset
  p_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!pllRun && clkPhaseLow) |=> (outEn == '0));

endmodule

// File: tb/clkfan_oe_ctrl_test.sv
module clkfan_oe_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        pwrGoodPin;
  logic [11:0] oePinN;
  logic        bwLoPin, bwHiPin, freqPin, refSelPin, clkPhaseLow;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [7:0]  regWrData;
  logic [7:0]  regRdData;
  logic [17:0] outEn;
  logic        pllRun;
  logic [1:0]  pllBwMode;
  logic [2:0]  freqSel;
  logic        refSelA;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  clkfan_oe_ctrl uut (
    .clk, .rstN, .pwrGoodPin, .oePinN, .bwLoPin, .bwHiPin, .freqPin,
    .refSelPin, .clkPhaseLow, .regWrEn, .regAddr, .regWrData, .regRdData,
    .outEn, .pllRun, .pllBwMode, .freqSel, .refSelA
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rstN = 1'b0; pwrGoodPin = 1'b0; oePinN = '1; bwLoPin = 1'b0; bwHiPin = 1'b1;
    freqPin = 1'b1; refSelPin = 1'b0; clkPhaseLow = 1'b1;
    regWrEn = 1'b0; regAddr = 2'd0; regWrData = 8'h00;
    waitN(3);
    rstN = 1'b1;
    waitN(2);
    chk("R11 outEn after reset", outEn, 18'h0);
    chk("R11 pllRun after reset", pllRun, 0);
    regRead(2'd0, d); chk("R8 reg0 reset", d, 8'hF5);
    regRead(2'd1, d); chk("R8 reg1 reset", d, 8'hFF);
    regRead(2'd2, d); chk("R8 reg2 reset", d, 8'hFF);
  endtask

  task automatic t_powerUp();
    oePinN = '0; bwLoPin = 1'b0; bwHiPin = 1'b1; freqPin = 1'b1;
    pwrGoodPin = 1'b1;
    waitN(6);
    chk("R4 pllRun up", pllRun, 1);
    chk("R4 all outputs run", outEn, 18'h3FFFF);
    chk("R5 high bw", pllBwMode, 2'b11);
    chk("R7 freq 100", freqSel, 3'b101);
  endtask

  task automatic t_groups();
    oePinN[0] = 1'b1; waitN(4);
    chk("R2 low group pin", outEn, 18'h3FFE0);
    oePinN[0] = 1'b0; oePinN[11] = 1'b1; waitN(4);
    chk("R2 high group pin", outEn, 18'h07FFF);
    oePinN[11] = 1'b0; oePinN[3] = 1'b1; waitN(4);
    chk("R2 single pin out7", outEn, 18'h3FF7F);
    oePinN[3] = 1'b0; waitN(4);
    chk("R1 pins all low", outEn, 18'h3FFFF);
  endtask

  task automatic t_regs();
    regWrite(2'd1, 8'hFE);
    chk("R1 reg1 bit0 off", outEn, 18'h3FFFE);
    regWrite(2'd0, 8'hD5);  // bit5 cleared, other fields unchanged
    chk("R8 reg0 bit5 out17 off", outEn, 18'h1FFFE);
    regWrite(2'd2, 8'h7F);
    chk("R8 reg2 bit7 out15 off", outEn, 18'h17FFE);
    regWrite(2'd0, 8'hF5); regWrite(2'd1, 8'hFF); regWrite(2'd2, 8'hFF);
    chk("R1 registers restored", outEn, 18'h3FFFF);
  endtask

  task automatic t_latency();
    @(negedge clk);
    oePinN[10] = 1'b1;      // output 14
    waitN(2);
    chk("R10 before third edge", outEn[14], 1);
    waitN(1);
    chk("R10 at third edge", outEn[14], 0);
    oePinN[10] = 1'b0; waitN(4);
  endtask

  task automatic t_phase();
    clkPhaseLow = 1'b0;
    oePinN[1] = 1'b1;       // output 5
    waitN(5);
    chk("R6 held in high phase", outEn, 18'h3FFFF);
    clkPhaseLow = 1'b1;
    waitN(1);
    chk("R6 applied in low phase", outEn, 18'h3FFDF);
    oePinN[1] = 1'b0; waitN(4);
  endtask

  task automatic t_powerCycle();
    logic [7:0] d;
    regWrite(2'd1, 8'h0F);
    pwrGoodPin = 1'b0;
    waitN(6);
    chk("R3 pllRun down", pllRun, 0);
    chk("R3 all Hi-Z", outEn, 18'h0);
    regRead(2'd1, d); chk("R3 reg1 retained", d, 8'h0F);
    bwLoPin = 1'b1; bwHiPin = 1'b0; freqPin = 1'b0;
    pwrGoodPin = 1'b1;
    waitN(6);
    chk("R4 outputs return", outEn, 18'h3FF0F);
    chk("R5 low bw", pllBwMode, 2'b00);
    chk("R7 freq 133", freqSel, 3'b001);
    regWrite(2'd0, 8'h35);
    chk("R7 software overwrite", freqSel, 3'b101);
    regWrite(2'd1, 8'hFF);
  endtask

  task automatic tri_cycle(input logic lo, input logic hi, input logic [1:0] exp, input string tag);
    pwrGoodPin = 1'b0; waitN(5);
    bwLoPin = lo; bwHiPin = hi;
    pwrGoodPin = 1'b1; waitN(6);
    chk(tag, pllBwMode, exp);
  endtask

  task automatic t_triLevel();
    tri_cycle(1'b0, 1'b0, 2'b10, "R5 bypass");
    tri_cycle(1'b1, 1'b1, 2'b11, "R5 both asserted");
  endtask

  task automatic t_readback();
    logic [7:0] d;
    refSelPin = 1'b1; freqPin = 1'b0; waitN(3);
    chk("R9 refSelA", refSelA, 1);
    regRead(2'd3, d); chk("R9 readback", d, 8'h01);
    regWrite(2'd3, 8'hFF);
    regRead(2'd3, d); chk("R9 write ignored", d, 8'h01);
    chk("R9 outputs untouched", outEn, 18'h3FFFF);
    refSelPin = 1'b0; freqPin = 1'b1; waitN(3);
    regRead(2'd3, d); chk("R9 input B", d, 8'h02);
  endtask

  initial begin
    t_reset();
    t_powerUp();
    t_groups();
    t_regs();
    t_latency();
    t_phase();
    t_powerCycle();
    t_triLevel();
    t_readback();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule